// File: doc/BRIEF.md
# Torus Adaptive Route Computation Unit

This purely combinational unit decides where a packet at one router input goes next in a two-dimensional torus. It receives the local node coordinates, the packet's destination, the virtual channel the packet currently holds, its message class, an ordered-class flag, the dimension the packet is currently travelling in, and one congestion flag for each network output. It returns the output port, the outgoing virtual channel index, and the dimension of the chosen port. The router feeds that dimension back into the packet header as the preference for the next hop.

Routes are always minimal. In each ring the shorter wraparound direction is taken. Packets on the adaptive channel may use either productive dimension, with a bias towards the one they are already travelling in. When every productive adaptive output is congested, a packet drains onto a fixed-route escape channel. Escape packets finish their current dimension before they turn. They switch between the two escape channels at a dateline that is set by a parameter, and they move back to the adaptive channel as soon as their fixed-route port is free. Ordered traffic always takes the fixed route in X-then-Y order, so that it keeps its order.

Top module: `torus_route_unit`

## Requirements
- R1: For each ring of size N, the productive direction is positive when (dst-cur) mod N <= N-(dst-cur) mod N, and negative otherwise. A tie therefore goes positive. Every output hop lowers the torus distance to the destination by exactly one.
- R2: When the destination equals the local node, port_o is 0 (local ejection) and dim_o is 0. chan_o then reflects the incoming channel, whatever the congestion.
- R3: A non-ordered adaptive packet leaves on its preferred dimension (pref_dim_i: 0 = X, 1 = Y) when that dimension still has hops left and its port is not congested.
- R4: A non-ordered adaptive packet takes the other productive dimension, on the adaptive channel, when the preferred dimension is exhausted or its port is congested, provided the other port is free.
- R5: A non-ordered adaptive packet whose productive ports are all congested drains onto an escape channel. It takes the fixed-route port: the preferred dimension if that still has hops, else the other dimension.
- R6: A non-ordered packet on an escape channel (vc_i 1 or 2) keeps the escape dimension until that dimension is exhausted. It never turns before the corner of its minimal rectangle.
- R7: An escape hop uses VC0 (vc 1) when the remaining path in the hop's dimension still contains the dateline link, and VC1 (vc 2) otherwise. With dateline coordinate D, the dateline link is D to D+1 going positive and D+1 to D going negative.
- R8: A non-ordered escape packet returns to the adaptive channel (vc 0) on its fixed-route port when that port is not congested.
- R9: An ordered packet (ordered_i = 1) always takes the escape fixed route, X first and then Y. It ignores pref_dim_i and the congestion flags.
- R10: chan_o = 3*cls_i + vc, where vc is 0 for adaptive, 1 for VC0 and 2 for VC1, cls_i 0 is request and cls_i 1 is response. Port codes are 0 local, 1 X+, 2 X-, 3 Y+, 4 Y-. Congestion bits are [0] X+, [1] X-, [2] Y+, [3] Y-.
- R11: dim_o is 0 for an X port and 1 for a Y port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cur_x_i | input | XW | Local node X coordinate |
| cur_y_i | input | YW | Local node Y coordinate |
| dst_x_i | input | XW | Destination X coordinate |
| dst_y_i | input | YW | Destination Y coordinate |
| vc_i | input | 2 | Incoming channel: 0 adaptive, 1 VC0, 2 VC1 |
| cls_i | input | 1 | Message class: 0 request, 1 response |
| ordered_i | input | 1 | Packet belongs to an ordered class |
| pref_dim_i | input | 1 | Dimension currently travelled: 0 X, 1 Y |
| congest_i | input | 4 | Congestion flag per network output port |
| port_o | output | 3 | Chosen output port |
| chan_o | output | 3 | Chosen virtual channel index within the class set |
| dim_o | output | 1 | Dimension of the chosen port |

## Verification
Two decisions can land on the same evaluation: draining into an escape channel and the escape dateline choice. Another such pair is a return to adaptive and the corner turn. Both cases are provoked with vectors whose congestion flags block the adaptive ports exactly when the fixed-route path crosses the dateline or reaches a corner. The result is judged against the port, channel and dimension computed in the bench. A hop-by-hop walk under full congestion, starting across the dateline, then confirms that every hop is productive, that no turn happens before the corner, and that the channel switches from VC0 to VC1 after the crossing.

// File: rtl/torus_route_unit.sv
module torus_route_unit #(
  parameter int X_SIZE = 8,
  parameter int Y_SIZE = 8,
  parameter int X_DATELINE = X_SIZE - 1,
  parameter int Y_DATELINE = Y_SIZE - 1,
  localparam int XW = (X_SIZE > 1) ? $clog2(X_SIZE) : 1,
  localparam int YW = (Y_SIZE > 1) ? $clog2(Y_SIZE) : 1
) (
  input  logic [XW-1:0] cur_x_i,
  input  logic [YW-1:0] cur_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  input  logic [1:0]    vc_i,
  input  logic          cls_i,
  input  logic          ordered_i,
  input  logic          pref_dim_i,
  input  logic [3:0]    congest_i,
  output logic [2:0]    port_o,
  output logic [2:0]    chan_o,
  output logic          dim_o
);
  localparam logic [2:0] P_LOCAL = 3'd0, P_XP = 3'd1, P_XN = 3'd2, P_YP = 3'd3, P_YN = 3'd4;
  localparam logic [1:0] VC_AD = 2'd0, VC_E0 = 2'd1, VC_E1 = 2'd2;

  function automatic int offs(int a, int b, int n);
    return (b >= a) ? b - a : b + n - a;
  endfunction

  function automatic logic crosses(int c, int len, logic pos, int dl, int n);
    return pos ? (offs(c, dl, n) < len) : (offs((dl + 1) % n, c, n) < len);
  endfunction

  int cx, cy, offx, offy, lenx, leny;
  logic x_pos, y_pos, x_live, y_live, x_cross, y_cross;
  logic [2:0] x_port, y_port;

  assign cx     = int'(cur_x_i);
  assign cy     = int'(cur_y_i);
  assign offx   = offs(cx, int'(dst_x_i), X_SIZE);
  assign offy   = offs(cy, int'(dst_y_i), Y_SIZE);
  assign x_pos  = offx <= X_SIZE - offx;
  assign y_pos  = offy <= Y_SIZE - offy;
  assign lenx   = x_pos ? offx : X_SIZE - offx;
  assign leny   = y_pos ? offy : Y_SIZE - offy;
  assign x_live = offx != 0;
  assign y_live = offy != 0;
  assign x_port = x_pos ? P_XP : P_XN;
  assign y_port = y_pos ? P_YP : P_YN;
  assign x_cross = crosses(cx, lenx, x_pos, X_DATELINE, X_SIZE);
  assign y_cross = crosses(cy, leny, y_pos, Y_DATELINE, Y_SIZE);

  function automatic logic busy(logic [2:0] p, logic [3:0] c);
    case (p)
      P_XP: return c[0];
      P_XN: return c[1];
      P_YP: return c[2];
      P_YN: return c[3];
      default: return 1'b0;
    endcase
  endfunction

  logic at_dest, esc_dim, pref_live, oth_live;
  logic [2:0] esc_port, pref_port, oth_port;
  logic [1:0] esc_vc, vsel;

  assign at_dest   = !x_live && !y_live;
  assign esc_dim   = ordered_i ? !x_live : (pref_dim_i ? y_live : !x_live);
  assign esc_port  = esc_dim ? y_port : x_port;
  assign esc_vc    = (esc_dim ? y_cross : x_cross) ? VC_E0 : VC_E1;
  assign pref_live = pref_dim_i ? y_live : x_live;
  assign oth_live  = pref_dim_i ? x_live : y_live;
  assign pref_port = pref_dim_i ? y_port : x_port;
  assign oth_port  = pref_dim_i ? x_port : y_port;

  always_comb begin
    port_o = esc_port;
    vsel   = esc_vc;
    dim_o  = esc_dim;
    if (at_dest) begin
      port_o = P_LOCAL;
      vsel   = vc_i;
      dim_o  = 1'b0;
    end else if (!ordered_i && vc_i == VC_AD) begin
      if (pref_live && !busy(pref_port, congest_i)) begin
        port_o = pref_port;
        vsel   = VC_AD;
        dim_o  = pref_dim_i;
      end else if (oth_live && !busy(oth_port, congest_i)) begin
        port_o = oth_port;
        vsel   = VC_AD;
        dim_o  = !pref_dim_i;
      end
    end else if (!ordered_i && !busy(esc_port, congest_i)) begin
      vsel = VC_AD;
    end
  end

  assign chan_o = cls_i ? 3'(vsel) + 3'd3 : 3'(vsel);

  always_comb begin
    AST_LOCAL_AT_DEST: assert ((port_o == P_LOCAL) == (cur_x_i == dst_x_i && cur_y_i == dst_y_i))
      else $error("local port mismatch"); // R2
    AST_PRODUCTIVE_HOP: assert (!(port_o == P_XP || port_o == P_XN) || (x_live && (port_o == P_XP) == x_pos))
      else $error("unproductive X hop"); // R1
    AST_PRODUCTIVE_Y: assert (!(port_o == P_YP || port_o == P_YN) || (y_live && (port_o == P_YP) == y_pos))
      else $error("unproductive Y hop"); // R1
    AST_ESC_NO_EARLY_TURN: assert (at_dest || ordered_i || vsel == VC_AD || !pref_live || dim_o == pref_dim_i)
      else $error("escape turned early"); // R6
    AST_ORDERED_FIXED: assert (at_dest || !ordered_i || (vsel != VC_AD && dim_o == !x_live))
      else $error("ordered left fixed route"); // R9
    AST_CLASS_SET: assert ((chan_o >= 3'd3) == cls_i && chan_o <= 3'd5)
      else $error("channel outside class set"); // R10
  end
endmodule

// File: tb/sim_torus_route_unit.sv
module sim_torus_route_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [2:0] cur_x = 3'd0, cur_y = 3'd0, dst_x = 3'd0, dst_y = 3'd0;
  logic [1:0] vc = 2'd0;
  logic cls = 1'b0, ord = 1'b0, pref = 1'b0;
  logic [3:0] cong = 4'd0;
  logic [2:0] port, chan;
  logic dim;

  int checks = 0;
  int failures = 0;

  torus_route_unit u0 (
    .cur_x_i(cur_x), .cur_y_i(cur_y), .dst_x_i(dst_x), .dst_y_i(dst_y),
    .vc_i(vc), .cls_i(cls), .ordered_i(ord), .pref_dim_i(pref), .congest_i(cong),
    .port_o(port), .chan_o(chan), .dim_o(dim)
  );

  typedef struct packed {
    logic [2:0] cx, cy, dx, dy;
    logic [1:0] v;
    logic c, o, p;
    logic [3:0] g;
    logic [2:0] eport, echan;
    logic edim;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{3'd1,3'd1,3'd3,3'd1,2'd0,1'b0,1'b0,1'b0,4'h0,3'd1,3'd0,1'b0,4'd1},  // R1 short positive
    '{3'd1,3'd1,3'd6,3'd1,2'd0,1'b0,1'b0,1'b0,4'h0,3'd2,3'd0,1'b0,4'd1},  // R1 wrap negative
    '{3'd0,3'd0,3'd4,3'd0,2'd0,1'b0,1'b0,1'b0,4'h0,3'd1,3'd0,1'b0,4'd1},  // R1 tie positive
    '{3'd7,3'd2,3'd1,3'd2,2'd0,1'b0,1'b0,1'b0,4'h0,3'd1,3'd0,1'b0,4'd1},  // R1 wrap positive
    '{3'd2,3'd2,3'd2,3'd2,2'd2,1'b1,1'b0,1'b0,4'h0,3'd0,3'd5,1'b0,4'd2},  // R2 escape at dest
    '{3'd1,3'd1,3'd3,3'd4,2'd0,1'b0,1'b0,1'b1,4'h0,3'd3,3'd0,1'b1,4'd3},  // R3 keep Y
    '{3'd1,3'd1,3'd3,3'd4,2'd0,1'b0,1'b0,1'b1,4'h4,3'd1,3'd0,1'b0,4'd4},  // R4 Y busy
    '{3'd1,3'd1,3'd1,3'd4,2'd0,1'b0,1'b0,1'b0,4'h0,3'd3,3'd0,1'b1,4'd4},  // R4 X exhausted
    '{3'd1,3'd1,3'd3,3'd4,2'd0,1'b0,1'b0,1'b0,4'h5,3'd1,3'd2,1'b0,4'd5},  // R5 drain VC1
    '{3'd6,3'd1,3'd1,3'd4,2'd0,1'b0,1'b0,1'b0,4'h5,3'd1,3'd1,1'b0,4'd7},  // R7 drain VC0 crossing
    '{3'd6,3'd1,3'd1,3'd4,2'd1,1'b0,1'b0,1'b0,4'h1,3'd1,3'd1,1'b0,4'd6},  // R6 no turn to free Y
    '{3'd6,3'd1,3'd1,3'd4,2'd1,1'b0,1'b0,1'b0,4'h0,3'd1,3'd0,1'b0,4'd8},  // R8 back to adaptive
    '{3'd1,3'd1,3'd3,3'd4,2'd2,1'b1,1'b0,1'b1,4'h4,3'd3,3'd5,1'b1,4'd6},  // R6 stay Y, response
    '{3'd1,3'd1,3'd3,3'd4,2'd0,1'b1,1'b1,1'b1,4'h0,3'd1,3'd5,1'b0,4'd9},  // R9 ordered X first
    '{3'd1,3'd1,3'd1,3'd4,2'd0,1'b0,1'b1,1'b0,4'h0,3'd3,3'd2,1'b1,4'd9},  // R9 ordered Y
    '{3'd1,3'd0,3'd6,3'd0,2'd1,1'b0,1'b0,1'b0,4'h2,3'd2,3'd1,1'b0,4'd7},  // R7 negative crossing
    '{3'd6,3'd0,3'd3,3'd0,2'd2,1'b0,1'b0,1'b0,4'h2,3'd2,3'd2,1'b0,4'd7},  // R7 negative no cross
    '{3'd5,3'd3,3'd5,3'd3,2'd0,1'b0,1'b0,1'b0,4'hF,3'd0,3'd0,1'b0,4'd10}  // R10 R2 adaptive local
  };

  function automatic int rdist(int a, int b);
    int f = (b - a + 8) % 8;
    return (f <= 8 - f) ? f : 8 - f;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(int x0, int y0, int x1, int y1, int v, int c, int o, int p, int g);
    @(posedge clk);
    cur_x = 3'(x0); cur_y = 3'(y0); dst_x = 3'(x1); dst_y = 3'(y1);
    vc = 2'(v); cls = 1'(c); ord = 1'(o); pref = 1'(p); cong = 4'(g);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset idle port", int'(port), 0);
    check("R10 reset idle chan", int'(chan), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t t = VECS[i];
      drive(t.cx, t.cy, t.dx, t.dy, t.v, t.c, t.o, t.p, t.g);
      check($sformatf("R%0d vec%0d port", t.req, i), int'(port), int'(t.eport));
      check($sformatf("R10 vec%0d chan", i), int'(chan), int'(t.echan));
      check($sformatf("R11 vec%0d dim", i), int'(dim), int'(t.edim));
    end

    // R1: sweep the X ring, every hop productive including ring edges
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        int nx;
        drive(a, 2, b, 2, 0, 0, 0, 0, 0);
        if (a == b) check("R2 sweep local", int'(port), 0);
        else begin
          nx = (port == 3'd1) ? (a + 1) % 8 : (a + 7) % 8;
          check("R1 sweep distance", rdist(nx, b), rdist(a, b) - 1);
          if (rdist(a, b) == 4) check("R1 sweep tie", int'(port), 1);
        end
      end
    end

    // R6 R7: hop-by-hop walk on escape under full congestion
    begin
      int x = 6, y = 5, p = 0, v = 1, hops = 0;
      bit crossed = 0;
      while (hops < 12) begin
        drive(x, y, 2, 1, v, 0, 0, p, 15);
        if (port == 3'd0) break;
        if (x != 2 && dim != 1'b0) check("R6 walk early turn", int'(dim), 0);
        if (dim == 1'b0) begin
          check("R7 walk x channel", int'(chan), crossed ? 2 : 1);
          if (x == 7) crossed = 1;
        end
        check("R1 walk port", int'(port), dim ? 3 : 1);
        if (dim == 1'b0) x = (x + 1) % 8; else y = (y + 1) % 8;
        v = int'(chan); p = int'(dim); hops++;
      end
      check("R1 walk hop count", hops, 8);
      check("R7 walk y channel", int'(v), 2);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule